// File: doc/BRIEF.md
# Ring-Oscillator Sampled Random Number Generator Register Block

This block is a small random number generator that software drives over a 32-bit register bus. Software first sets a sample count. It then writes a control word that picks the output length, picks one of four oscillator speeds, enables the unit and raises a start bit. The block then gathers one entropy bit per sample interval into an output buffer of up to 256 bits. It drops the start bit when the last bit has arrived, and software reads the result from eight data words.

The physical oscillators are not part of the block. A single behavioural entropy input stands in for them. It is sampled once per interval, and the interval is the sample count multiplied by a divider of 1, 2, 4 or 8 that the speed field selects. Control writes carry their own bit mask in the upper halfword, so software can change one field without first reading the register back.

Top module: `osc_rng_regs`

## Requirements
- R1: After reset the control register (0x0), the sample count register (0x4) and all eight data words read as zero.
- R2: Control register bit fields: start = bit 0, enable = bit 1, speed = bits [3:2], length = bits [5:4]. A write to 0x0 changes control bit i (i in 0..5) only when write bit 16+i is set. Masked-off bits keep their value, bits [31:6] read as zero, and without a control write the enable, speed and length fields do not change.
- R3: A write that would leave start at 1 while enable ends up at 0 is ignored for start. Start reads 0 and the data words are not touched.
- R4: While a run is active, one entropy bit is taken every max(N,1) * 2^speed clock cycles, where N is the sample count register. The first bit is taken that many cycles after the edge that accepts the start write.
- R5: The length field selects 64 * (length + 1) bits (0 = 64, 1 = 128, 2 = 192, 3 = 256). Start clears on the same clock edge that takes the last bit, and enable, speed and length are left as written.
- R6: Sample k (k = 0 first) is stored at bit k mod 32 of the data word at 0x10 + 4 * (k div 32). A new start zeroes all data words, so bits beyond the selected length read as zero.
- R7: The data words keep their value while start is 0, including across control writes that do not start a run. They change only during a run that a new start begins.
- R8: Writing 0xFFFF0000 to 0x0 clears every control field, which disables the unit and stops a run at once. Bits already collected stay unchanged.
- R9: The sample count register at 0x4 reads back the value last written (16 bits wide). Addresses outside 0x0, 0x4 and 0x10..0x2C read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 8 | Byte address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ent_bit | input | 1 | Behavioural entropy source, sampled at each interval |

## Verification
The main function is swept over every length and every speed, at sample counts of 1, 2 and 3, with one extra run at a sample count of 0. An entropy stream that changes every cycle means any off-by-one in the interval, a wrong first-sample cycle or a misplaced bit shows up as a data mismatch. Reading start one cycle before and one cycle after the computed last sample pins the completion edge for each length. Separate patterns cover masked writes that touch a single field, a start written with enable low, and a full clear in mid-run, which shows whether the partial data is frozen and whether the words past the collected bits stay zero.

// File: rtl/osc_rng_pkg.sv
package osc_rng_pkg;

  localparam int CTRL_BITS = 6;
  localparam int MASK_LSB  = 16;

  localparam int unsigned CTRL_OFS = 32'h00;
  localparam int unsigned SCNT_OFS = 32'h04;
  localparam int unsigned DATA_OFS = 32'h10;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] speed;
    logic       enable;
    logic       start;
  } ctrl_t;

endpackage

// File: rtl/osc_rng_ctrl.sv
module osc_rng_ctrl
  import osc_rng_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  input  logic        done,
  output ctrl_t       ctrl_q,
  output ctrl_t       ctrl_nx,
  output logic        go
);

  logic [CTRL_BITS-1:0] wr_val;
  logic [CTRL_BITS-1:0] wr_msk;
  logic [CTRL_BITS-1:0] base;
  logic                 ctrl_en;

  always_comb begin
    wr_val     = wdata[CTRL_BITS-1:0];
    wr_msk     = wdata[MASK_LSB +: CTRL_BITS];
    base       = ctrl_q;
    base[0]    = ctrl_q.start & ~done;
    ctrl_nx    = ctrl_t'(base);
    go         = 1'b0;
    if (wr_ctrl) begin
      ctrl_nx = ctrl_t'((base & ~wr_msk) | (wr_val & wr_msk));
      if (!ctrl_nx.enable) begin
        ctrl_nx.start = 1'b0;
      end
      go = wr_msk[0] & wr_val[0] & ctrl_nx.enable;
    end
  end

  assign ctrl_en = wr_ctrl | done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_nx;
    end
  end

endmodule

// File: rtl/osc_rng_pacer.sv
module osc_rng_pacer #(
  parameter int CNT_W = 16,
  localparam int IV_W = CNT_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             run,
  input  logic [CNT_W-1:0] sample_cnt,
  input  logic [1:0]       speed,
  output logic             strobe,
  output logic [IV_W-1:0]  ival_q,
  output logic [IV_W-1:0]  tick_q
);

  logic [IV_W-1:0] ival_base;
  logic [IV_W-1:0] ival_nx;
  logic [IV_W-1:0] tick_nx;
  logic            tick_en;

  always_comb begin
    ival_base = (sample_cnt == '0) ? IV_W'(1) : IV_W'(sample_cnt);
    ival_nx   = ival_base << speed;
  end

  assign strobe  = run && (tick_q == ival_q - IV_W'(1));
  assign tick_en = go | run;

  always_comb begin
    if (go || strobe) begin
      tick_nx = '0;
    end else begin
      tick_nx = tick_q + IV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q <= IV_W'(1);
    end else if (go) begin
      ival_q <= ival_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (tick_en) begin
      tick_q <= tick_nx;
    end
  end

endmodule

// File: rtl/osc_rng_collect.sv
module osc_rng_collect #(
  parameter int OUT_BITS = 256,
  localparam int WORDS = OUT_BITS / 32,
  localparam int IDX_W = $clog2(OUT_BITS),
  localparam int SEL_W = IDX_W - 5,
  localparam int QTR   = OUT_BITS / 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [1:0]          len_nx,
  input  logic                strobe,
  input  logic                ent_bit,
  output logic                done,
  output logic [OUT_BITS-1:0] data_q
);

  logic [1:0]       len_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_nx;
  logic [IDX_W:0]   span;
  logic             idx_en;

  always_comb begin
    span = (IDX_W+1)'({1'b0, len_q} + 3'd1) * (IDX_W+1)'(QTR);
    done = strobe && ({1'b0, idx_q} == span - (IDX_W+1)'(1));
  end

  assign idx_en = go | strobe;
  assign idx_nx = go ? '0 : idx_q + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (go) begin
      len_q <= len_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_nx;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic        hit;
    logic        word_en;
    logic [31:0] word_nx;

    assign hit     = strobe && (idx_q[IDX_W-1:5] == SEL_W'(w));
    assign word_en = go | hit;

    always_comb begin
      word_nx = data_q[w*32 +: 32];
      if (go) begin
        word_nx = '0;
      end else if (hit) begin
        word_nx[idx_q[4:0]] = ent_bit;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[w*32 +: 32] <= '0;
      end else if (word_en) begin
        data_q[w*32 +: 32] <= word_nx;
      end
    end
  end

endmodule

// File: rtl/osc_rng_regs.sv
module osc_rng_regs
  import osc_rng_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 16,
  parameter int OUT_BITS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ent_bit
);

  localparam int WORDS = OUT_BITS / 32;
  localparam int WSEL  = $clog2(WORDS);
  localparam int IV_W  = CNT_W + 3;

  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic wr_ctrl;
  logic wr_scnt;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
  assign wr_scnt = bus_wr && (bus_addr == ADDR_W'(SCNT_OFS));

  logic [CNT_W-1:0] scnt_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      scnt_q <= '0;
    end else if (wr_scnt) begin
      scnt_q <= bus_wdata[CNT_W-1:0];
    end
  end

  ctrl_t                ctrl_q;
  ctrl_t                ctrl_nx;
  logic                 go;
  logic                 done;
  logic                 strobe;
  logic [IV_W-1:0]      ival_q;
  logic [IV_W-1:0]      tick_q;
  logic [OUT_BITS-1:0]  data_q;

  osc_rng_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_ctrl (wr_ctrl),
    .wdata   (bus_wdata),
    .done    (done),
    .ctrl_q  (ctrl_q),
    .ctrl_nx (ctrl_nx),
    .go      (go)
  );

  osc_rng_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .go         (go),
    .run        (ctrl_q.start),
    .sample_cnt (scnt_q),
    .speed      (ctrl_nx.speed),
    .strobe     (strobe),
    .ival_q     (ival_q),
    .tick_q     (tick_q)
  );

  osc_rng_collect #(.OUT_BITS(OUT_BITS)) u_collect (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .go      (go),
    .len_nx  (ctrl_nx.len),
    .strobe  (strobe),
    .ent_bit (ent_bit),
    .done    (done),
    .data_q  (data_q)
  );

  logic [31:0] dword [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_rd
    assign dword[w] = data_q[w*32 +: 32];
  end

  logic [ADDR_W-1:0] data_off;
  logic              data_hit;

  always_comb begin
    data_off = bus_addr - ADDR_W'(DATA_OFS);
    data_hit = (bus_addr >= ADDR_W'(DATA_OFS)) &&
               (data_off < ADDR_W'(WORDS * 4)) &&
               (bus_addr[1:0] == 2'b00);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_OFS)) begin
      bus_rdata[CTRL_BITS-1:0] = ctrl_q;
    end else if (bus_addr == ADDR_W'(SCNT_OFS)) begin
      bus_rdata[CNT_W-1:0] = scnt_q;
    end else if (data_hit) begin
      bus_rdata = dword[data_off[WSEL+1:2]];
    end
  end

endmodule

// File: rtl/osc_rng_regs_chk.sv
module osc_rng_regs_chk #(
  parameter int ADDR_W   = 8,
  parameter int IV_W     = 19,
  parameter int OUT_BITS = 256
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [5:0]          ctrl_bits,
  input logic                strobe,
  input logic [IV_W-1:0]     ival_q,
  input logic [IV_W-1:0]     tick_q,
  input logic [OUT_BITS-1:0] data_q
);

  // R3
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_bits[0]) |-> ctrl_bits[1]);

  // R2
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (ctrl_bits[5:1] == $past(ctrl_bits[5:1])));

  // R8
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && bus_wdata == 32'hFFFF_0000) |=> (ctrl_bits == '0));

  // R5
  end_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_bits[0]) && !$past(bus_wr)) |-> $past(strobe));

  // R4
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q < ival_q);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_bits[0] |=> (ctrl_bits[0] || $stable(data_q)));

endmodule

bind osc_rng_regs osc_rng_regs_chk #(
  .ADDR_W   (ADDR_W),
  .IV_W     (IV_W),
  .OUT_BITS (OUT_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ctrl_bits (ctrl_q),
  .strobe    (strobe),
  .ival_q    (ival_q),
  .tick_q    (tick_q),
  .data_q    (data_q)
);

// File: tb/osc_rng_regs_tb_top.sv
`timescale 1ns/1ps
module osc_rng_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ent_bit;
  logic [31:0] cyc = '0;

  int errors = 0;
  int checks = 0;

  logic [31:0] exp_w [8];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 32'd1;

  function automatic logic ent_f(input logic [31:0] n);
    logic [31:0] h;
    h = n * 32'h9E37_79B1;
    return h[17] ^ h[29] ^ h[5];
  endfunction

  assign ent_bit = ent_f(cyc);

  osc_rng_regs dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ent_bit   (ent_bit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge; c0 = cycle count before the write edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output logic [31:0] c0);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    c0        = cyc;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic build_exp(input logic [31:0] c0, input int iv, input int nbits);
    for (int w = 0; w < 8; w++) begin
      exp_w[w] = '0;
      for (int b = 0; b < 32; b++) begin
        int k;
        k = w * 32 + b;
        if (k < nbits) exp_w[w][b] = ent_f(c0 + 32'((k + 1) * iv));
      end
    end
  endtask

  task automatic check_words(input string tag);
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      bus_read(8'(8'h10 + 4 * w), d);
      chk(tag, d, exp_w[w]);
    end
  endtask

  task automatic run_case(input int n, input int spd, input int len);
    logic [31:0] c0;
    logic [31:0] d;
    int iv;
    int nbits;
    iv    = ((n == 0) ? 1 : n) << spd;
    nbits = 64 * (len + 1);
    bus_write(8'h04, 32'(n), c0);
    bus_write(8'h00, 32'h003F_0000 | 32'(len << 4) | 32'(spd << 2) | 32'h3, c0);
    while (cyc != c0 + 32'(nbits * iv)) @(negedge clk);
    bus_read(8'h00, d);
    chk("R5/R4 start still set before last sample", d, 32'(len << 4) | 32'(spd << 2) | 32'h3);
    @(negedge clk);
    bus_read(8'h00, d);
    chk("R5 start cleared at last sample", d, 32'(len << 4) | 32'(spd << 2) | 32'h2);
    build_exp(c0, iv, nbits);
    check_words("R6/R4 data words");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] c0;
    logic [31:0] d;
    logic [31:0] keep0;

    wait_cycles(5);
    rst_n = 1'b1;
    wait_cycles(4);

    // R1 reset state
    bus_read(8'h00, d); chk("R1 ctrl after reset", d, 32'h0);
    bus_read(8'h04, d); chk("R1 sample count after reset", d, 32'h0);
    for (int w = 0; w < 8; w++) exp_w[w] = '0;
    check_words("R1 data after reset");

    // R9 sample count readback and unmapped addresses
    bus_write(8'h04, 32'h1234_ABCD, c0);
    bus_read(8'h04, d); chk("R9 sample count readback", d, 32'h0000_ABCD);
    bus_read(8'h08, d); chk("R9 unmapped 0x08", d, 32'h0);
    bus_read(8'h30, d); chk("R9 unmapped 0x30", d, 32'h0);

    // R2 masked writes
    bus_write(8'h00, 32'h0000_003E, c0);
    bus_read(8'h00, d); chk("R2 zero mask no change", d, 32'h0);
    bus_write(8'h00, 32'h000C_0008, c0);
    bus_read(8'h00, d); chk("R2 speed only", d, 32'h08);
    bus_write(8'h00, 32'h0030_003F, c0);
    bus_read(8'h00, d); chk("R2 length only, speed kept", d, 32'h38);
    bus_write(8'h00, 32'hFFFF_0000, c0);
    bus_read(8'h00, d); chk("R8 full clear idle", d, 32'h0);

    // R4 sample count zero acts as one
    run_case(0, 0, 0);

    // R4 R5 R6 sweep
    for (int n = 1; n <= 3; n++)
      for (int spd = 0; spd < 4; spd++)
        for (int len = 0; len < 4; len++)
          run_case(n, spd, len);

    // R7 control write without start keeps data
    bus_write(8'h00, 32'h0030_0000, c0);
    bus_read(8'h00, d); chk("R7 length changed", d, 32'h0E);
    wait_cycles(10);
    check_words("R7 data kept after config write");

    // R3 start with enable cleared
    bus_write(8'h00, 32'h0003_0001, c0);
    bus_read(8'h00, d); chk("R3 start ignored, enable 0", d, 32'h0C);
    wait_cycles(20);
    check_words("R3 data untouched");

    // R8 abort mid-run
    bus_write(8'h04, 32'd10, c0);
    bus_write(8'h00, 32'h003F_003F, c0);
    wait_cycles(500);
    bus_read(8'h00, d); chk("R8 run active before clear", d, 32'h3F);
    bus_write(8'h00, 32'hFFFF_0000, c0);
    bus_read(8'h00, d); chk("R8 cleared mid-run", d, 32'h0);
    build_exp(c0 - 32'd501, 80, (c0 - (c0 - 32'd501)) / 80);
    bus_read(8'h10, keep0);
    chk("R6/R8 partial word0", keep0, exp_w[0]);
    wait_cycles(3000);
    check_words("R8/R6 data frozen after abort");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule